// File: doc/BRIEF.md
# Ethernet Receive Destination Filter with Multicast Hash

This block sits at the front of a receive path and decides, for each incoming frame, whether the frame is kept or discarded. It looks at the first fourteen header bytes as they stream in, one byte per clock, and then at the frame's total length. From these it sorts the frame into one of three classes: broadcast, multicast or unicast. It then applies the policy bits of a 32-bit control word, a 48-bit station address and a 64-bin multicast hash table supplied by the surrounding logic.

While the six destination bytes arrive, a reflected CRC-32 is accumulated over them. Six bits taken from that CRC select one bin of the hash table. When the length is presented, the block computes its verdict and registers it. It reports the verdict with a one-cycle valid pulse, together with the broadcast and multicast flags that the downstream DMA engine stores in its receive descriptor.

Top module: `rx_addr_filter`

## Requirements
- R1: The hash runs a reflected CRC-32 over the six destination bytes. Each byte is processed least-significant bit first, with polynomial 0xEDB88320, start value 0xFFFFFFFF and no final inversion. The 6-bit index is {crc[24], crc[25], crc[26], crc[27], crc[28], crc[29]}, with crc[24] as the most significant bit. Index bit 5 picks the table word (0 = `hash_tbl_lo`, 1 = `hash_tbl_hi`), and index bits 4:0 pick the bit within that word.
- R2: A destination of six 0xFF bytes is broadcast. A broadcast frame passes the address stage only if control bit 12 (receive-all) or control bit 17 (broadcast enable) is 1.
- R3: A destination whose bytes 0..2 are 01, 00, 5E and whose byte 3 is 0x7F or lower is multicast; 0x80 and above in byte 3 is not multicast. A multicast frame passes when control bit 12 or control bit 16 (all-multicast) is 1.
- R4: A multicast frame that R3 does not pass is accepted only if control bit 9 (hash enable) is 1 and the table bit selected by R1 is 1.
- R5: Any other destination passes only under control bit 12 or on an exact match with the station address. Byte 0 is `sta_addr_hi[15:8]`, byte 1 is `sta_addr_hi[7:0]`, and bytes 2..5 are `sta_addr_lo[31:24]` down to `sta_addr_lo[7:0]`.
- R6: A frame longer than 1514 bytes is rejected. When header bytes 12..13 hold 0x8100, the limit is 1518 bytes instead. This check also applies when receive-all is set.
- R7: `dec_bcast` and `dec_mcast` report the frame's class whatever the verdict and whatever the control bits. They are never both 1.
- R8: `dec_valid` pulses for exactly one cycle, in the cycle after `rx_len_vld`, and carries the verdict for that length. After reset, all outputs are 0.
- R9: A byte marked with `rx_sof` restarts header capture and the hash, so any partial header that came before it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte_vld | input | 1 | Header byte strobe |
| rx_sof | input | 1 | Marks the first header byte of a frame |
| rx_byte | input | 8 | Header byte, destination byte 0 first |
| rx_len_vld | input | 1 | Frame length strobe, given after the 14th header byte |
| rx_len | input | 16 | Total frame length in bytes, excluding the CRC |
| ctrl_word | input | 32 | Policy bits 9, 12, 16, 17 as in R2 to R5 |
| sta_addr_hi | input | 16 | Station address bytes 0 and 1 |
| sta_addr_lo | input | 32 | Station address bytes 2 to 5 |
| hash_tbl_lo | input | 32 | Hash bins 0 to 31 |
| hash_tbl_hi | input | 32 | Hash bins 32 to 63 |
| dec_valid | output | 1 | Verdict strobe |
| dec_accept | output | 1 | 1 = keep frame |
| dec_bcast | output | 1 | Frame is broadcast |
| dec_mcast | output | 1 | Frame is multicast |

## Verification
A wrong CRC state or a wrong bin select shows up only on multicast frames that depend on the hash. It appears on `dec_accept` in the cycle after the length strobe. The bench therefore walks a one-hot table across all 64 bins for a fixed address, which exposes any wrong index bit or wrong word select on the first affected bin. A stale header position shows after a restarted header, because the wrong bytes would change the class flags or the station-address match. Length-limit faults appear only at the exact boundary lengths, so both sides of each limit are driven.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int HDR_BYTES = 14;
    localparam int DST_BYTES = 6;
    localparam int TYPE_POS  = 12;
    localparam int HASH_W    = 6;

    localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
    localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

    localparam int CTL_HASH_EN   = 9;
    localparam int CTL_RX_ALL    = 12;
    localparam int CTL_MCAST_ALL = 16;
    localparam int CTL_BCAST_EN  = 17;

    localparam logic [15:0] VLAN_TYPE = 16'h8100;

    typedef struct packed {
        logic [DST_BYTES-1:0][7:0] dst;   // dst[k] is destination byte k
        logic [15:0]               etype;
    } hdr_t;

    typedef enum logic [1:0] {
        CLS_UNI   = 2'd0,
        CLS_BCAST = 2'd1,
        CLS_MCAST = 2'd2
    } cls_e;

    typedef struct packed {
        logic accept;
        logic bcast;
        logic mcast;
    } verdict_t;

    // One byte of reflected CRC-32, least-significant bit first.
    function automatic logic [31:0] crc_step(logic [31:0] c, logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'd0, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

    // Reverse bits 31:24 and keep the upper HASH_W bits of the result.
    function automatic logic [HASH_W-1:0] hash_index(logic [31:0] c);
        logic [HASH_W-1:0] idx;
        for (int i = 0; i < HASH_W; i++) begin
            idx[HASH_W-1-i] = c[24+i];
        end
        return idx;
    endfunction

endpackage

// File: rtl/rxf_hdr_capture.sv
module rxf_hdr_capture
    import rxf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       byte_vld,
    input  logic       sof,
    input  logic [7:0] byte_in,
    output hdr_t       hdr,
    output logic       crc_en,
    output logic       crc_restart,
    output logic       hdr_done
);
    localparam int POS_W = $clog2(HDR_BYTES + 1);
    localparam logic [POS_W-1:0] POS_END  = POS_W'(HDR_BYTES);
    localparam logic [POS_W-1:0] POS_DST  = POS_W'(DST_BYTES);
    localparam logic [POS_W-1:0] POS_TYPE = POS_W'(TYPE_POS);

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_now;
    logic             take;
    hdr_t             hdr_q;

    assign pos_now = sof ? '0 : pos_q;
    assign take    = byte_vld && (sof || (pos_q < POS_END));

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            hdr_q <= '0;
        end else if (take) begin
            pos_q <= pos_now + POS_W'(1);
            for (int k = 0; k < DST_BYTES; k++) begin
                if (pos_now == POS_W'(k)) begin
                    hdr_q.dst[k] <= byte_in;
                end
            end
            if (pos_now == POS_TYPE) begin
                hdr_q.etype[15:8] <= byte_in;
            end
            if (pos_now == POS_TYPE + POS_W'(1)) begin
                hdr_q.etype[7:0] <= byte_in;
            end
        end
    end

    assign hdr         = hdr_q;
    assign crc_en      = take && (pos_now < POS_DST);
    assign crc_restart = (pos_now == '0);
    assign hdr_done    = (pos_q == POS_END);

    // R9: a start byte always lands in slot 0, so the next slot is 1
    assert_sof_restart_R9: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && sof) |=> (pos_q == POS_W'(1)));

endmodule

// File: rtl/rxf_hash_crc.sv
module rxf_hash_crc
    import rxf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              restart,
    input  logic [7:0]        byte_in,
    output logic [HASH_W-1:0] idx
);
    logic [31:0] crc_q;
    logic [31:0] crc_base;

    assign crc_base = restart ? CRC_INIT : crc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= CRC_INIT;
        end else if (en) begin
            crc_q <= crc_step(crc_base, byte_in);
        end
    end

    assign idx = hash_index(crc_q);

    // R1: the hash index only moves while destination bytes arrive
    assert_hash_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(idx));

endmodule

// File: rtl/rxf_classify.sv
module rxf_classify
    import rxf_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int MAX_PLAIN  = 1514,
    parameter int MAX_TAGGED = 1518
) (
    input  hdr_t              hdr,
    input  logic [HASH_W-1:0] idx,
    input  logic [LEN_W-1:0]  len,
    input  logic [31:0]       ctrl,
    input  logic [15:0]       sta_hi,
    input  logic [31:0]       sta_lo,
    input  logic [31:0]       tbl_lo,
    input  logic [31:0]       tbl_hi,
    output verdict_t          verdict
);
    localparam int TBL_SEL = HASH_W - 1;

    logic [DST_BYTES-1:0][7:0] station;
    logic [DST_BYTES-1:0]      byte_ff;
    logic [DST_BYTES-1:0]      byte_eq;
    logic                      rx_all;
    logic                      is_bcast;
    logic                      is_mcast;
    logic                      hash_bit;
    logic                      len_ok;
    logic                      addr_ok;
    cls_e                      cls;
    logic                      ctrl_unused;

    assign station[0] = sta_hi[15:8];
    assign station[1] = sta_hi[7:0];
    assign station[2] = sta_lo[31:24];
    assign station[3] = sta_lo[23:16];
    assign station[4] = sta_lo[15:8];
    assign station[5] = sta_lo[7:0];

    for (genvar k = 0; k < DST_BYTES; k++) begin : g_cmp
        assign byte_ff[k] = (hdr.dst[k] == 8'hFF);
        assign byte_eq[k] = (hdr.dst[k] == station[k]);
    end

    assign is_bcast = &byte_ff;
    assign is_mcast = (hdr.dst[0] == 8'h01) && (hdr.dst[1] == 8'h00) &&
                      (hdr.dst[2] == 8'h5E) && !hdr.dst[3][7];

    always_comb begin
        if (is_bcast)      cls = CLS_BCAST;
        else if (is_mcast) cls = CLS_MCAST;
        else               cls = CLS_UNI;
    end

    assign rx_all   = ctrl[CTL_RX_ALL];
    assign hash_bit = idx[TBL_SEL] ? tbl_hi[idx[TBL_SEL-1:0]] : tbl_lo[idx[TBL_SEL-1:0]];

    always_comb begin
        case (cls)
            CLS_BCAST: addr_ok = rx_all || ctrl[CTL_BCAST_EN];
            CLS_MCAST: addr_ok = rx_all || ctrl[CTL_MCAST_ALL] ||
                                 (ctrl[CTL_HASH_EN] && hash_bit);
            default:   addr_ok = rx_all || (&byte_eq);
        endcase
    end

    assign len_ok = (hdr.etype == VLAN_TYPE) ? (len <= LEN_W'(MAX_TAGGED))
                                             : (len <= LEN_W'(MAX_PLAIN));

    assign verdict.accept = addr_ok && len_ok;
    assign verdict.bcast  = (cls == CLS_BCAST);
    assign verdict.mcast  = (cls == CLS_MCAST);

    assign ctrl_unused = ^ctrl;

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int MAX_PLAIN  = 1514,
    parameter int MAX_TAGGED = 1518
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_byte_vld,
    input  logic             rx_sof,
    input  logic [7:0]       rx_byte,
    input  logic             rx_len_vld,
    input  logic [LEN_W-1:0] rx_len,
    input  logic [31:0]      ctrl_word,
    input  logic [15:0]      sta_addr_hi,
    input  logic [31:0]      sta_addr_lo,
    input  logic [31:0]      hash_tbl_lo,
    input  logic [31:0]      hash_tbl_hi,
    output logic             dec_valid,
    output logic             dec_accept,
    output logic             dec_bcast,
    output logic             dec_mcast
);
    hdr_t              hdr;
    logic              crc_en;
    logic              crc_restart;
    logic              hdr_done;
    logic [HASH_W-1:0] idx;
    verdict_t          verdict_c;
    verdict_t          verdict_q;
    logic              valid_q;

    rxf_hdr_capture u_cap (
        .clk         (clk),
        .rst         (rst),
        .byte_vld    (rx_byte_vld),
        .sof         (rx_sof),
        .byte_in     (rx_byte),
        .hdr         (hdr),
        .crc_en      (crc_en),
        .crc_restart (crc_restart),
        .hdr_done    (hdr_done)
    );

    rxf_hash_crc u_crc (
        .clk     (clk),
        .rst     (rst),
        .en      (crc_en),
        .restart (crc_restart),
        .byte_in (rx_byte),
        .idx     (idx)
    );

    rxf_classify #(
        .LEN_W      (LEN_W),
        .MAX_PLAIN  (MAX_PLAIN),
        .MAX_TAGGED (MAX_TAGGED)
    ) u_cls (
        .hdr     (hdr),
        .idx     (idx),
        .len     (rx_len),
        .ctrl    (ctrl_word),
        .sta_hi  (sta_addr_hi),
        .sta_lo  (sta_addr_lo),
        .tbl_lo  (hash_tbl_lo),
        .tbl_hi  (hash_tbl_hi),
        .verdict (verdict_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q   <= 1'b0;
            verdict_q <= '0;
        end else begin
            valid_q <= rx_len_vld;
            if (rx_len_vld) begin
                verdict_q <= verdict_c;
            end
        end
    end

    assign dec_valid  = valid_q;
    assign dec_accept = verdict_q.accept;
    assign dec_bcast  = verdict_q.bcast;
    assign dec_mcast  = verdict_q.mcast;

    assert_valid_follows_len_R8: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> $past(rx_len_vld));

    assert_len_after_header_R8: assert property (@(posedge clk) disable iff (rst)
        rx_len_vld |-> hdr_done);

    assert_bcast_policy_R2: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_bcast && dec_accept) |->
            $past(ctrl_word[CTL_RX_ALL] || ctrl_word[CTL_BCAST_EN]));

    assert_len_limit_R6: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_accept) |-> ($past(rx_len) <= LEN_W'(MAX_TAGGED)));

    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> !(dec_bcast && dec_mcast));

endmodule

// File: tb/rx_addr_filter_tb_top.sv
`timescale 1ns/1ps
module rx_addr_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_byte_vld = 1'b0;
    logic        rx_sof = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        rx_len_vld = 1'b0;
    logic [15:0] rx_len = 16'd0;
    logic [31:0] ctrl_word = 32'd0;
    logic [15:0] sta_addr_hi = 16'h0211;
    logic [31:0] sta_addr_lo = 32'h2233_4455;
    logic [31:0] hash_tbl_lo = 32'd0;
    logic [31:0] hash_tbl_hi = 32'd0;
    logic        dec_valid, dec_accept, dec_bcast, dec_mcast;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    localparam logic [47:0] STATION = 48'h0211_2233_4455;

    always #2.5 clk = ~clk;

    rx_addr_filter dut_i (
        .clk(clk), .rst(rst),
        .rx_byte_vld(rx_byte_vld), .rx_sof(rx_sof), .rx_byte(rx_byte),
        .rx_len_vld(rx_len_vld), .rx_len(rx_len),
        .ctrl_word(ctrl_word), .sta_addr_hi(sta_addr_hi), .sta_addr_lo(sta_addr_lo),
        .hash_tbl_lo(hash_tbl_lo), .hash_tbl_hi(hash_tbl_hi),
        .dec_valid(dec_valid), .dec_accept(dec_accept),
        .dec_bcast(dec_bcast), .dec_mcast(dec_mcast)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Bit-serial reference hash: index bits from crc[24] (msb) to crc[29].
    function automatic int ref_hash(input logic [47:0] d);
        logic [31:0] c = 32'hFFFF_FFFF;
        logic [7:0]  b;
        logic        fb;
        int          h = 0;
        for (int n = 0; n < 6; n++) begin
            b = d[47-8*n -: 8];
            for (int j = 0; j < 8; j++) begin
                fb = c[0] ^ b[j];
                c  = {1'b0, c[31:1]};
                if (fb) c = c ^ 32'hEDB8_8320;
            end
        end
        for (int i = 0; i < 6; i++) h = h * 2 + int'(c[24+i]);
        return h;
    endfunction

    function automatic logic tbl_bit(input int h);
        return (h >= 32) ? hash_tbl_hi[h-32] : hash_tbl_lo[h];
    endfunction

    task automatic send(input logic [47:0] d, input logic [15:0] et,
                        input logic [15:0] len, input int junk);
        for (int i = 0; i < junk; i++) begin
            @(negedge clk);
            rx_byte_vld = 1'b1; rx_sof = (i == 0); rx_byte = 8'hFF;
        end
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            rx_byte_vld = 1'b1;
            rx_sof      = (i == 0);
            if (i < 6)        rx_byte = d[47-8*i -: 8];
            else if (i == 12) rx_byte = et[15:8];
            else if (i == 13) rx_byte = et[7:0];
            else              rx_byte = 8'hA0 + 8'(i);
        end
        @(negedge clk);
        rx_byte_vld = 1'b0; rx_sof = 1'b0;
        rx_len_vld  = 1'b1; rx_len = len;
        @(negedge clk);
        rx_len_vld  = 1'b0;
    endtask

    task automatic run_case(input string req, input logic [47:0] d,
                            input logic [15:0] et, input logic [15:0] len, input int junk);
        logic bc, mc, pass, ok_len, rx_all;
        rx_all = ctrl_word[12];
        bc = (d == 48'hFFFF_FFFF_FFFF);
        mc = (d[47:24] == 24'h01_005E) && (d[23:16] <= 8'h7F);
        ok_len = (et == 16'h8100) ? (len <= 16'd1518) : (len <= 16'd1514);
        if (bc)      pass = rx_all || ctrl_word[17];
        else if (mc) pass = rx_all || ctrl_word[16] || (ctrl_word[9] && tbl_bit(ref_hash(d)));
        else         pass = rx_all || (d == STATION);
        send(d, et, len, junk);
        chk("R8 valid", int'(dec_valid), 1);
        chk(req, int'(dec_accept), int'(pass && ok_len));
        chk("R7 bcast", int'(dec_bcast), int'(bc));
        chk("R7 mcast", int'(dec_mcast), int'(mc));
        @(negedge clk);
        chk("R8 pulse", int'(dec_valid), 0);
    endtask

    initial begin
        logic [47:0] mdst;
        int          h;
        repeat (3) @(negedge clk);
        chk("R8 reset valid", int'(dec_valid), 0);
        chk("R8 reset accept", int'(dec_accept), 0);
        rst = 1'b0;
        @(negedge clk);

        for (int c = 0; c < 16; c++) begin
            ctrl_word = 32'h0000_0108 | (c[0] ? 32'h1000 : 0) | (c[1] ? 32'h2_0000 : 0)
                      | (c[2] ? 32'h1_0000 : 0) | (c[3] ? 32'h0200 : 0);
            mdst = {24'h01_005E, 1'b0, 4'(c), 3'b101, 8'(c * 37), 8'(c) ^ 8'h3C};
            h = ref_hash(mdst);
            hash_tbl_lo = (h < 32) ? (32'd1 << h) : 32'd0;
            hash_tbl_hi = (h >= 32) ? (32'd1 << (h - 32)) : 32'd0;
            run_case("R2 bcast", 48'hFFFF_FFFF_FFFF, 16'h0800, 16'd64, 0);
            run_case("R4 mcast hash hit", mdst, 16'h0800, 16'd100, 0);
            run_case("R3 mcast byte3 0x7F", 48'h01_005E_7F_0001, 16'h0800, 16'd80, 0);
            run_case("R5 byte3 0x80 not mcast", 48'h01_005E_80_0001, 16'h0800, 16'd80, 0);
            run_case("R5 station match", STATION, 16'h0800, 16'd60, 0);
            run_case("R5 station miss", STATION ^ 48'h1, 16'h0800, 16'd60, 0);
            run_case("R5 station miss byte0", STATION ^ 48'h0100_0000_0000, 16'h0800, 16'd60, 0);
            run_case("R6 len 1514", STATION, 16'h0800, 16'd1514, 0);
            run_case("R6 len 1515", STATION, 16'h0800, 16'd1515, 0);
            run_case("R6 tagged 1518", STATION, 16'h8100, 16'd1518, 0);
            run_case("R6 tagged 1519", STATION, 16'h8100, 16'd1519, 0);
            run_case("R6 bcast 1515", 48'hFFFF_FFFF_FFFF, 16'h0800, 16'd1515, 0);
            run_case("R9 restart", STATION, 16'h0800, 16'd70, 5);
            run_case("R9 restart bcast", 48'hFFFF_FFFF_FFFF, 16'h0800, 16'd70, 3);
            hash_tbl_lo = ~hash_tbl_lo;
            hash_tbl_hi = ~hash_tbl_hi;
            run_case("R4 mcast hash miss", mdst, 16'h0800, 16'd100, 0);
        end

        // R1: one-hot walk over all 64 bins for a fixed address
        ctrl_word = 32'h0000_0200;
        mdst = 48'h01_005E_2A_10_C7;
        h = ref_hash(mdst);
        for (int b = 0; b < 64; b++) begin
            hash_tbl_lo = (b < 32) ? (32'd1 << b) : 32'd0;
            hash_tbl_hi = (b >= 32) ? (32'd1 << (b - 32)) : 32'd0;
            send(mdst, 16'h0800, 16'd64, 0);
            chk("R1 bin select", int'(dec_accept), int'(b == h));
            @(negedge clk);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule